// File: doc/BRIEF.md
# Sub-Sample Reference Pulse Accumulator

This block builds a fine-resolution reference pulse shape out of coarsely sampled detector pulses. Each incoming pulse is already detected and amplitude-normalised. It arrives as a fixed number of ADC samples together with a sub-sample phase that says where, inside one ADC interval, the pulse started. The block splits every ADC interval into `SUB` phase bins. It scatters each sample into the bin array at a position set by its sample index and by the pulse phase. A sum memory and a hit-count memory are updated by read-modify-write.

Once `N_PULSES` pulses have been taken in, the block runs a final pass with two parts. First it divides every bin sum by its hit count. Then it smooths the averages with a centred moving average of `2*HALF_WIN+1` taps. The result is written to an output memory that the user reads through a registered read port. A ready/valid handshake lets the upstream pulse source simply lose pulses while the block is busy. Dropping pulses is harmless for a calibration function of this kind.

Top module: `ref_pulse_accum`

## Requirements
- R1: Reset clears the sum and hit-count memories in a pass of `SUB*PULSE_LEN` cycles. During this pass `in_ready` is low. After the pass `in_ready` is high and `done` stays low.
- R2: Sample k of a pulse sits at bits `[k*SAMP_W +: SAMP_W]` of `in_samples`, and k=0 is the earliest sample. With phase p it is added to bin `SUB*k + p`. Phase 0 denotes a pulse starting just before a sample edge. Phase `SUB-1` denotes a pulse starting just after one.
- R3: Each sample is accumulated by a three-cycle read-modify-write: read, add, write back. A pulse is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low for exactly `3*PULSE_LEN` cycles and returns high afterwards, unless the final pass has begun.
- R4: A pulse offered while `in_ready` is low is ignored and leaves no trace in the result.
- R5: A hit-count memory records how many samples have landed in each bin. The final pass starts once `N_PULSES` pulses have been accumulated. From then on `in_ready` stays low.
- R6: The average of a bin is floor(sum / hit count).
- R7: A bin with a hit count of zero has an average of zero, and no division is started for it.
- R8: Output bin i is (S * floor(2^RECIP_F / n)) >> RECIP_F. Here S is the sum of the averages of bins i-HALF_WIN to i+HALF_WIN and n is the number of taps. Where the full window fits, n = 2*HALF_WIN+1.
- R9: Near the ends of the array the window is cut to the bins that exist. S and n then cover only those bins, and the same formula applies.
- R10: `done` rises once every output bin has been written, and stays high until reset. `ref_data` shows the output bin at `ref_addr` one cycle after the address is presented.
- R11: After `done`, offered pulses are refused and the output memory keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pulse is offered |
| in_ready | output | 1 | Block can take a pulse this cycle |
| in_phase | input | $clog2(SUB) | Sub-sample start phase of the pulse |
| in_samples | input | PULSE_LEN*SAMP_W | Pulse samples, sample k at bits [k*SAMP_W +: SAMP_W] |
| done | output | 1 | Reference pulse complete |
| ref_addr | input | $clog2(SUB*PULSE_LEN) | Output memory read address |
| ref_data | output | SAMP_W | Output bin value, one cycle after ref_addr |

## Verification
The assertions take two things for granted. First, reset is applied before the block is used. Second, the hit counts never exceed `N_PULSES`, which holds because each pulse touches a bin at most once. On that basis they check the read-modify-write spacing, the bound on the pulse count, that division never starts with a zero divisor, and that `done` is sticky. The stimulus holds each offered pulse until it is taken, and it offers decoy pulses only inside the busy window. It uses phases at both extremes and phases left unused, so that zero-count bins appear. It includes full-scale samples, so that the sum width is exercised. It picks a window wider than a third of the array, so that both truncated ends and a fully covered middle are checked.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
   typedef enum logic [3:0] {
      ST_CLR, ST_IDLE, ST_RD, ST_ADD, ST_WR,
      ST_AVG_RD, ST_AVG_CHK, ST_AVG_WAIT,
      ST_PRE_RD, ST_PRE_ACC, ST_OUT,
      ST_INC_RD, ST_INC_ACC, ST_DEC_RD, ST_DEC_ACC, ST_DONE
   } rpa_state_e;
endpackage

// File: rtl/rpa_ram.sv
module rpa_ram #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 1024,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   if (DEPTH != (1 << AW)) begin : g_bad_depth
      $error("rpa_ram: DEPTH must be a power of two");
   end

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/rpa_div.sv
module rpa_div #(
   parameter int NUM_W = 16,
   parameter int DEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             done,
   output logic [NUM_W-1:0] quot
);
   localparam int LW = $clog2(NUM_W + 1);

   if (NUM_W < 2 || DEN_W < 1) begin : g_bad_w
      $error("rpa_div: operand widths too small");
   end

   logic [NUM_W-1:0] q;
   logic [DEN_W-1:0] r, den_q;
   logic [LW-1:0]    left;
   logic             busy;
   logic [DEN_W:0]   trial;

   always_comb trial = {r, q[NUM_W-1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0; r <= '0; den_q <= '0; left <= '0;
         busy <= 1'b0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            q <= num; r <= '0; den_q <= den;
            left <= LW'(NUM_W); busy <= 1'b1;
         end else if (busy) begin
            if (trial >= {1'b0, den_q}) begin
               r <= DEN_W'(trial - {1'b0, den_q});
               q <= {q[NUM_W-2:0], 1'b1};
            end else begin
               r <= trial[DEN_W-1:0];
               q <= {q[NUM_W-2:0], 1'b0};
            end
            left <= left - 1'b1;
            if (left == LW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign quot = q;
endmodule

// File: rtl/ref_pulse_accum.sv
module ref_pulse_accum
   import rpa_pkg::*;
#(
   parameter int SAMP_W    = 12,
   parameter int SUB       = 256,
   parameter int PULSE_LEN = 4,
   parameter int N_PULSES  = 8192,
   parameter int HALF_WIN  = 24,
   parameter int RECIP_F   = 16,
   localparam int PH_W     = $clog2(SUB),
   localparam int NBINS    = SUB * PULSE_LEN,
   localparam int BIN_W    = $clog2(NBINS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [PH_W-1:0]               in_phase,
   input  logic [PULSE_LEN*SAMP_W-1:0]   in_samples,
   output logic                          done,
   input  logic [BIN_W-1:0]              ref_addr,
   output logic [SAMP_W-1:0]             ref_data
);
   localparam int K_W      = $clog2(PULSE_LEN);
   localparam int CNT_W    = $clog2(N_PULSES + 1);
   localparam int SUM_W    = SAMP_W + CNT_W;
   localparam int WIN      = 2 * HALF_WIN + 1;
   localparam int TAP_W    = $clog2(WIN + 1);
   localparam int S_W      = SAMP_W + TAP_W;
   localparam int RW       = RECIP_F + 1;
   localparam int PW       = S_W + RW;
   localparam int PRE_LAST = (HALF_WIN < NBINS - 1) ? HALF_WIN : NBINS - 1;
   localparam longint ONE  = 64'd1 << RECIP_F;

   // elaboration-time parameter checks
   if (SUB < 2 || (SUB & (SUB - 1)) != 0) begin : g_bad_sub
      $error("ref_pulse_accum: SUB must be a power of two >= 2");
   end
   if (PULSE_LEN < 2 || (PULSE_LEN & (PULSE_LEN - 1)) != 0) begin : g_bad_len
      $error("ref_pulse_accum: PULSE_LEN must be a power of two >= 2");
   end
   if (N_PULSES < 1 || HALF_WIN < 0 || RECIP_F < 8 || RECIP_F > 30) begin : g_bad_misc
      $error("ref_pulse_accum: N_PULSES, HALF_WIN or RECIP_F out of range");
   end

   // reciprocal table of the tap count, floor(2^F / n)
   logic [RW-1:0] recip_tab [1 << TAP_W];
   for (genvar g = 0; g < (1 << TAP_W); g++) begin : g_recip
      if (g == 0) begin : g_zero
         assign recip_tab[g] = '0;
      end else begin : g_val
         assign recip_tab[g] = RW'(ONE / g);
      end
   end

   rpa_state_e state;
   logic [PULSE_LEN*SAMP_W-1:0] samp_q;
   logic [PH_W-1:0]   ph_q;
   logic [K_W-1:0]    k_q;
   logic [CNT_W-1:0]  pulses_q;
   logic [BIN_W-1:0]  bin_q, sm_j, sm_i;
   logic [S_W-1:0]    win_sum;
   logic [SUM_W-1:0]  sum_new_q, sum_rd, sum_wdata;
   logic [CNT_W-1:0]  cnt_new_q, cnt_rd, cnt_wdata;
   logic              done_q;

   logic [BIN_W-1:0]  acc_addr, sc_raddr, sc_waddr, avg_raddr;
   logic              sc_we, avg_we, ref_we, div_start, div_done;
   logic [SAMP_W-1:0] avg_wdata, avg_rd, ref_wdata, cur_samp;
   logic [SUM_W-1:0]  div_q;
   logic [TAP_W-1:0]  taps;
   logic [PW-1:0]     prod;
   int                lo_i, hi_i;

   always_comb begin
      acc_addr = {k_q, ph_q};
      cur_samp = samp_q[int'(k_q)*SAMP_W +: SAMP_W];
      sc_raddr = (state == ST_AVG_RD || state == ST_AVG_CHK || state == ST_AVG_WAIT)
                 ? bin_q : acc_addr;
      sc_we     = (state == ST_CLR) || (state == ST_WR);
      sc_waddr  = (state == ST_CLR) ? bin_q : acc_addr;
      sum_wdata = (state == ST_CLR) ? '0 : sum_new_q;
      cnt_wdata = (state == ST_CLR) ? '0 : cnt_new_q;

      div_start = (state == ST_AVG_CHK) && (cnt_rd != '0);
      avg_we    = ((state == ST_AVG_CHK) && (cnt_rd == '0)) ||
                  ((state == ST_AVG_WAIT) && div_done);
      avg_wdata = (state == ST_AVG_CHK) ? '0 : SAMP_W'(div_q);

      case (state)
         ST_INC_RD: avg_raddr = BIN_W'(int'(sm_i) + HALF_WIN + 1);
         ST_DEC_RD: avg_raddr = BIN_W'(int'(sm_i) - HALF_WIN);
         default:   avg_raddr = sm_j;
      endcase

      lo_i = (int'(sm_i) >= HALF_WIN) ? int'(sm_i) - HALF_WIN : 0;
      hi_i = (int'(sm_i) + HALF_WIN <= NBINS - 1) ? int'(sm_i) + HALF_WIN : NBINS - 1;
      taps = TAP_W'(hi_i - lo_i + 1);
      prod = PW'(win_sum) * PW'(recip_tab[taps]);
      ref_wdata = SAMP_W'(prod >> RECIP_F);
      ref_we    = (state == ST_OUT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_CLR;
         samp_q <= '0; ph_q <= '0; k_q <= '0; pulses_q <= '0;
         bin_q <= '0; sm_j <= '0; sm_i <= '0; win_sum <= '0;
         sum_new_q <= '0; cnt_new_q <= '0; done_q <= 1'b0;
      end else begin
         case (state)
            ST_CLR: begin
               if (int'(bin_q) == NBINS - 1) begin
                  bin_q <= '0;
                  state <= ST_IDLE;
               end else bin_q <= bin_q + 1'b1;
            end
            ST_IDLE: if (in_valid) begin
               samp_q <= in_samples;
               ph_q   <= in_phase;
               k_q    <= '0;
               state  <= ST_RD;
            end
            ST_RD:  state <= ST_ADD;
            ST_ADD: begin
               sum_new_q <= sum_rd + SUM_W'(cur_samp);
               cnt_new_q <= cnt_rd + 1'b1;
               state     <= ST_WR;
            end
            ST_WR: begin
               if (int'(k_q) == PULSE_LEN - 1) begin
                  pulses_q <= pulses_q + 1'b1;
                  state <= (int'(pulses_q) == N_PULSES - 1) ? ST_AVG_RD : ST_IDLE;
               end else begin
                  k_q   <= k_q + 1'b1;
                  state <= ST_RD;
               end
            end
            ST_AVG_RD:   state <= ST_AVG_CHK;
            ST_AVG_CHK,
            ST_AVG_WAIT: if (avg_we) begin
               if (int'(bin_q) == NBINS - 1) begin
                  sm_j    <= '0;
                  win_sum <= '0;
                  state   <= ST_PRE_RD;
               end else begin
                  bin_q <= bin_q + 1'b1;
                  state <= ST_AVG_RD;
               end
            end else if (state == ST_AVG_CHK) state <= ST_AVG_WAIT;
            ST_PRE_RD: state <= ST_PRE_ACC;
            ST_PRE_ACC: begin
               win_sum <= win_sum + S_W'(avg_rd);
               if (int'(sm_j) == PRE_LAST) begin
                  sm_i  <= '0;
                  state <= ST_OUT;
               end else begin
                  sm_j  <= sm_j + 1'b1;
                  state <= ST_PRE_RD;
               end
            end
            ST_OUT: begin
               if (int'(sm_i) == NBINS - 1) begin
                  done_q <= 1'b1;
                  state  <= ST_DONE;
               end else if (int'(sm_i) + HALF_WIN + 1 <= NBINS - 1) state <= ST_INC_RD;
               else if (int'(sm_i) >= HALF_WIN) state <= ST_DEC_RD;
               else sm_i <= sm_i + 1'b1;
            end
            ST_INC_RD: state <= ST_INC_ACC;
            ST_INC_ACC: begin
               win_sum <= win_sum + S_W'(avg_rd);
               if (int'(sm_i) >= HALF_WIN) state <= ST_DEC_RD;
               else begin
                  sm_i  <= sm_i + 1'b1;
                  state <= ST_OUT;
               end
            end
            ST_DEC_RD: state <= ST_DEC_ACC;
            ST_DEC_ACC: begin
               win_sum <= win_sum - S_W'(avg_rd);
               sm_i    <= sm_i + 1'b1;
               state   <= ST_OUT;
            end
            default: state <= ST_DONE;
         endcase
      end
   end

   assign in_ready = (state == ST_IDLE);
   assign done     = done_q;

   rpa_ram #(.WIDTH(SUM_W), .DEPTH(NBINS)) u_sum_ram (
      .clk(clk), .we(sc_we), .waddr(sc_waddr), .wdata(sum_wdata),
      .raddr(sc_raddr), .rdata(sum_rd));

   rpa_ram #(.WIDTH(CNT_W), .DEPTH(NBINS)) u_cnt_ram (
      .clk(clk), .we(sc_we), .waddr(sc_waddr), .wdata(cnt_wdata),
      .raddr(sc_raddr), .rdata(cnt_rd));

   rpa_ram #(.WIDTH(SAMP_W), .DEPTH(NBINS)) u_avg_ram (
      .clk(clk), .we(avg_we), .waddr(bin_q), .wdata(avg_wdata),
      .raddr(avg_raddr), .rdata(avg_rd));

   rpa_ram #(.WIDTH(SAMP_W), .DEPTH(NBINS)) u_ref_ram (
      .clk(clk), .we(ref_we), .waddr(sm_i), .wdata(ref_wdata),
      .raddr(ref_addr), .rdata(ref_data));

   rpa_div #(.NUM_W(SUM_W), .DEN_W(CNT_W)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start), .num(sum_rd),
      .den(cnt_rd), .done(div_done), .quot(div_q));
endmodule

// File: rtl/ref_pulse_accum_chk.sv
module ref_pulse_accum_chk
   import rpa_pkg::*;
#(
   parameter int N_PULSES = 8192,
   parameter int CNT_W    = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             done,
   input rpa_state_e       st,
   input logic             div_start,
   input logic [CNT_W-1:0] div_den,
   input logic [CNT_W-1:0] pulses
);
   // R3: a taken pulse blocks the next cycle
   assert_accept_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R3: every write-back comes two cycles after its read
   assert_rmw_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WR) |-> ($past(st, 2) == ST_RD));

   // R5: accumulated pulse count never passes the target
   assert_pulse_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pulses) <= N_PULSES);

   // R5 / R11: once complete, nothing is accepted
   assert_done_refuses_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !in_ready);

   // R7: division never starts on an empty bin
   assert_no_zero_divide_R7: assert property (@(posedge clk) disable iff (!rst_n)
      div_start |-> (div_den != '0));

   // R10: completion flag is sticky
   assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
endmodule

bind ref_pulse_accum ref_pulse_accum_chk #(.N_PULSES(N_PULSES), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .done(done), .st(state), .div_start(div_start), .div_den(cnt_rd),
   .pulses(pulses_q));

// File: tb/ref_pulse_accum_tb.sv
`timescale 1ns/1ps
module ref_pulse_accum_tb;
   localparam int SW = 12, SUB = 16, LEN = 4, NP = 12, H = 24, F = 16;
   localparam int NB = SUB * LEN;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
   logic in_ready, done;
   logic [3:0] in_phase = '0;
   logic [LEN*SW-1:0] in_samples = '0;
   logic [5:0] ref_addr = '0;
   logic [SW-1:0] ref_data;

   ref_pulse_accum #(.SAMP_W(SW), .SUB(SUB), .PULSE_LEN(LEN), .N_PULSES(NP),
                     .HALF_WIN(H), .RECIP_F(F)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_phase(in_phase), .in_samples(in_samples), .done(done),
      .ref_addr(ref_addr), .ref_data(ref_data));

   always #2.5 clk = ~clk;

   int n_checks = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural model
   longint m_sum [NB];
   longint m_cnt [NB];
   longint m_ref [NB];
   int busy_left = NB;
   bit m_clear = 1'b1, m_final = 1'b0;
   int m_pulses = 0;

   initial for (int i = 0; i < NB; i++) begin m_sum[i] = 0; m_cnt[i] = 0; end

   always @(posedge clk) begin
      if (!rst_n) begin
         busy_left = NB; m_clear = 1'b1;
      end else if (busy_left > 0) begin
         busy_left--;
         if (busy_left == 0) m_clear = 1'b0;
      end else if (!m_final && in_valid) begin
         for (int k = 0; k < LEN; k++) begin
            m_sum[k*SUB + int'(in_phase)] += longint'(in_samples[k*SW +: SW]);
            m_cnt[k*SUB + int'(in_phase)] += 1;
         end
         m_pulses++;
         busy_left = 3 * LEN;
         if (m_pulses == NP) m_final = 1'b1;
      end
   end

   // ready compared on every cycle
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (m_clear)      check("R1 ready during clear", in_ready, 0);
         else if (m_final) check("R5 ready after last pulse", in_ready, 0);
         else              check("R3 R4 ready", in_ready, (busy_left == 0) ? 1 : 0);
      end
   end

   function automatic logic [SW-1:0] sval(input int p, input int k);
      if (p == 1) return '1;
      return SW'((p * 1237 + k * 911 + 400) % 4096);
   endfunction

   task automatic send(input int p, input int ph, input bit decoy, input int gap);
      in_phase = 4'(ph);
      for (int k = 0; k < LEN; k++) in_samples[k*SW +: SW] = sval(p, k);
      in_valid = 1'b1;
      while (in_ready !== 1'b1) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (decoy) begin
         // R4: offered while busy, must be ignored
         in_phase = 4'(ph ^ 1);
         for (int k = 0; k < LEN; k++) in_samples[k*SW +: SW] = 12'd3000;
         in_valid = 1'b1;
         repeat (3) @(negedge clk);
         in_valid = 1'b0;
      end
      repeat (gap) @(negedge clk);
   endtask

   task automatic build_ref();
      longint avg [NB];
      for (int i = 0; i < NB; i++) avg[i] = (m_cnt[i] == 0) ? 0 : m_sum[i] / m_cnt[i];
      for (int i = 0; i < NB; i++) begin
         int lo, hi;
         longint s;
         lo = (i - H < 0) ? 0 : i - H;
         hi = (i + H > NB - 1) ? NB - 1 : i + H;
         s = 0;
         for (int j = lo; j <= hi; j++) s += avg[j];
         m_ref[i] = (s * ((longint'(1) << F) / (hi - lo + 1))) >> F;
      end
   endtask

   initial begin
      int ph [NP] = '{0, 15, 0, 15, 3, 7, 3, 9, 0, 12, 15, 5};
      int waited;
      repeat (3) @(negedge clk);
      check("R1 ready in reset", in_ready, 0);
      check("R1 done in reset", done, 0);
      rst_n = 1'b1;
      repeat (NB + 2) @(negedge clk);
      check("R1 ready after clear", in_ready, 1);
      for (int p = 0; p < NP; p++) begin
         send(p, ph[p], (p % 3) == 1, (p % 2 == 0) ? 0 : 4);
         if (p < NP - 1) check("R10 done not early", done, 0);
      end
      check("R5 done not yet after last pulse", done, 0);
      waited = 0;
      while (done !== 1'b1 && waited < 20000) begin @(negedge clk); waited++; end
      check("R10 done reached", done, 1);
      build_ref();
      for (int i = 0; i < NB; i++) begin
         ref_addr = 6'(i);
         @(negedge clk);
         if (i < H || i > NB - 1 - H)
            check($sformatf("R9 R2 R6 R7 edge bin %0d", i), ref_data, m_ref[i]);
         else
            check($sformatf("R8 R2 R6 R7 full bin %0d", i), ref_data, m_ref[i]);
      end
      // R11: offers after completion are refused
      in_phase = 4'd2;
      in_samples = '1;
      in_valid = 1'b1;
      repeat (10) @(negedge clk);
      in_valid = 1'b0;
      check("R10 done sticky", done, 1);
      for (int t = 0; t < 3; t++) begin
         int b;
         b = (t == 0) ? 0 : ((t == 1) ? 34 : NB - 1);
         ref_addr = 6'(b);
         @(negedge clk);
         check($sformatf("R11 bin %0d unchanged", b), ref_data, m_ref[b]);
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule